// File: doc/BRIEF.md
# Panel Raster Scaler with Visible Window

This block sits between a fixed-resolution panel timing source and a pixel fetch
stage. For every panel pixel strobe it reports which source pixel should be shown
there, or that the pixel is a black border. Source coordinates come from two
fixed-point accumulators, one per axis. Each accumulator steps by an inverse scale
factor with 12 fractional bits, computed by software as (4096 x source size) / panel
size. A step of 4096 maps one source pixel to one panel pixel. A smaller step
enlarges the image and a larger step shrinks it.

Software programs an inclusive visible window on each axis. Panel pixels outside
that rectangle come out blank. An image narrower than the panel can therefore be
centred: the start is set to (panel width - scaled width) / 2 and the end to panel
width - start - 1. The accumulators count from zero at the window's first column and
first line.

Two further controls handle corner cases:
- A horizontal override replaces the x step with a separately programmed value, so that horizontal scaling can match vertical scaling.
- A line limit clamps the source line index so that fetches never run past the last line of the source.

Top module: `fp_scaler`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_strobe`, `out_valid`, `out_src_x` and `out_src_y` are all 0.
- R2: `out_strobe` rises exactly one clock after a cycle with `pix_en` high. A `pix_en` that coincides with `line_start` or `frame_start` produces no output strobe.
- R3: A pixel is visible when its column c satisfies hstart <= c <= hend and its line l satisfies vstart <= l <= vend, both bounds inclusive. A visible pixel gives `out_valid`=1. Any other strobed pixel gives `out_valid`=0 with `out_src_x`=0 and `out_src_y`=0.
- R4: Column c is 0 for the first `pix_en` after a line or frame start and increments by one per `pix_en`. For a visible pixel, `out_src_x` = floor((c - hstart) x xstep / 4096), so a step of 4096 gives the identity map.
- R5: Line l is 0 after `frame_start` and increments by one per `line_start`. For a visible pixel, `out_src_y` = floor((l - vstart) x `cfg_ystep` / 4096).
- R6: When bit 12 of `cfg_xovr` is 1, the x step is twice the value in bits 11:0 of `cfg_xovr`, and `cfg_xstep` has no effect. When bit 12 is 0, the x step is `cfg_xstep`.
- R7: When bit 28 of `cfg_line_limit` is 1, a visible pixel's `out_src_y` is min(R5 value, bits 27:16 of `cfg_line_limit`). When bit 28 is 0, no clamp applies, whatever bits 27:16 hold.
- R8: `frame_start` restarts both the column and the line count. It takes priority over a `line_start` in the same cycle, so the line count becomes 0, not 1.
- R9: Cycles with no strobe do not advance the column. On such cycles `out_strobe` and `out_valid` are 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Pulse: first line of a panel frame begins |
| line_start | input | 1 | Pulse: next panel line begins |
| pix_en | input | 1 | Pulse: one panel pixel in the current line |
| cfg_xstep | input | STEP_W (16) | Horizontal inverse scale step, 12 fractional bits |
| cfg_ystep | input | STEP_W (16) | Vertical inverse scale step, 12 fractional bits |
| cfg_xovr | input | FRAC_W+1 (13) | Horizontal override: bit 12 enable, bits 11:0 half step |
| cfg_line_limit | input | CFG_W (32) | Line clamp: bit 28 enable, bits 27:16 last source line |
| cfg_hwin_start | input | COORD_W (12) | First visible panel column |
| cfg_hwin_end | input | COORD_W (12) | Last visible panel column |
| cfg_vwin_start | input | COORD_W (12) | First visible panel line |
| cfg_vwin_end | input | COORD_W (12) | Last visible panel line |
| out_strobe | output | 1 | Registered pixel strobe |
| out_valid | output | 1 | Pixel lies inside the visible window |
| out_src_x | output | STEP_W+COORD_W-FRAC_W (16) | Source column index |
| out_src_y | output | STEP_W+COORD_W-FRAC_W (16) | Source line index |

## Verification
The bound assertions check, on every clock, the properties that follow from the output pins alone:
- strobe timing and the suppression of a strobe when `pix_en` coincides with a line or frame start;
- `out_valid` never appearing without `out_strobe`;
- zero coordinates on blank pixels;
- the clamp bound whenever the line limit is enabled.

The arithmetic of the index mapping depends on hidden position counts, so only the bench's cycle-accurate reference can show it. That covers identity, enlarging and shrinking steps, the override replacing the x step, the window edges including a one-column window, and frame restarts in mid-frame.

// File: rtl/fp_scaler_pkg.sv
package fp_scaler_pkg;

  // Inclusive range test used by both axes.
  function automatic logic win_hit(input int unsigned pos,
                                   input int unsigned lo,
                                   input int unsigned hi);
    return (pos >= lo) && (pos <= hi);
  endfunction

  // Fractional weight of one step of 1:1 mapping for a given fraction width.
  function automatic int unsigned unity_step(input int unsigned frac_w);
    return 32'd1 << frac_w;
  endfunction

endpackage

// File: rtl/fp_scaler_stepsel.sv
module fp_scaler_stepsel #(
  parameter int STEP_W = 16,
  parameter int FRAC_W = 12
) (
  input  logic [STEP_W-1:0] base_step,
  input  logic [FRAC_W:0]   ovr,
  output logic [STEP_W-1:0] eff_step
);
  localparam int PAD_W = STEP_W - FRAC_W - 1;

  logic [STEP_W-1:0] forced_step;

  generate
    if (PAD_W > 0) begin : g_pad
      assign forced_step = {{PAD_W{1'b0}}, ovr[FRAC_W-1:0], 1'b0};
    end else begin : g_trim
      assign forced_step = STEP_W'({ovr[FRAC_W-1:0], 1'b0});
    end
  endgenerate

  always_comb begin
    if (ovr[FRAC_W]) eff_step = forced_step;
    else             eff_step = base_step;
  end
endmodule

// File: rtl/fp_scaler_axis.sv
module fp_scaler_axis #(
  parameter int POS_W  = 12,
  parameter int STEP_W = 16,
  parameter int ACC_W  = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              advance,
  input  logic [STEP_W-1:0] step,
  input  logic [POS_W-1:0]  win_lo,
  input  logic [POS_W-1:0]  win_hi,
  output logic [POS_W-1:0]  pos,
  output logic [ACC_W-1:0]  acc,
  output logic              in_win
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic past_lo;

  assign past_lo = (pos >= win_lo);
  assign in_win  = fp_scaler_pkg::win_hit(32'(pos), 32'(win_lo), 32'(win_hi));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pos <= '0;
      acc <= '0;
    end else if (advance) begin
      if (pos != POS_MAX) pos <= pos + 1'b1;
      if (past_lo)        acc <= acc + ACC_W'(step);
    end
  end
endmodule

// File: rtl/fp_scaler_out.sv
module fp_scaler_out #(
  parameter int IDX_W  = 16,
  parameter int FRAC_W = 12,
  parameter int LIM_W  = 12,
  parameter int ACC_W  = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic             x_in_win,
  input  logic             y_in_win,
  input  logic [ACC_W-1:0] x_acc,
  input  logic [ACC_W-1:0] y_acc,
  input  logic             lim_en,
  input  logic [LIM_W-1:0] lim_line,
  output logic             strobe_q,
  output logic             valid_q,
  output logic [IDX_W-1:0] sx_q,
  output logic [IDX_W-1:0] sy_q
);
  logic [IDX_W-1:0] x_int;
  logic [IDX_W-1:0] y_int;
  logic [IDX_W-1:0] y_lim;
  logic [IDX_W-1:0] y_sel;
  logic             visible;

  assign x_int   = x_acc[FRAC_W +: IDX_W];
  assign y_int   = y_acc[FRAC_W +: IDX_W];
  assign y_lim   = IDX_W'(lim_line);
  assign visible = x_in_win && y_in_win;

  always_comb begin
    if (lim_en && (y_int > y_lim)) y_sel = y_lim;
    else                           y_sel = y_int;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      valid_q  <= 1'b0;
      sx_q     <= '0;
      sy_q     <= '0;
    end else begin
      strobe_q <= fire;
      if (fire) begin
        valid_q <= visible;
        sx_q    <= visible ? x_int : '0;
        sy_q    <= visible ? y_sel : '0;
      end else begin
        valid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fp_scaler.sv
module fp_scaler #(
  parameter int COORD_W    = 12,
  parameter int FRAC_W     = 12,
  parameter int STEP_W     = 16,
  parameter int CFG_W      = 32,
  parameter int LIM_W      = 12,
  parameter int LIM_LSB    = 16,
  parameter int LIM_EN_BIT = 28
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              frame_start,
  input  logic                              line_start,
  input  logic                              pix_en,
  input  logic [STEP_W-1:0]                 cfg_xstep,
  input  logic [STEP_W-1:0]                 cfg_ystep,
  input  logic [FRAC_W:0]                   cfg_xovr,
  input  logic [CFG_W-1:0]                  cfg_line_limit,
  input  logic [COORD_W-1:0]                cfg_hwin_start,
  input  logic [COORD_W-1:0]                cfg_hwin_end,
  input  logic [COORD_W-1:0]                cfg_vwin_start,
  input  logic [COORD_W-1:0]                cfg_vwin_end,
  output logic                              out_strobe,
  output logic                              out_valid,
  output logic [STEP_W+COORD_W-FRAC_W-1:0]  out_src_x,
  output logic [STEP_W+COORD_W-FRAC_W-1:0]  out_src_y
);
  localparam int ACC_W = STEP_W + COORD_W;
  localparam int IDX_W = ACC_W - FRAC_W;

  logic [STEP_W-1:0]  x_step;
  logic [COORD_W-1:0] x_pos, y_pos;
  logic [ACC_W-1:0]   x_acc, y_acc;
  logic               x_in_win, y_in_win;
  logic               x_restart, fire;
  logic               lim_en;
  logic [LIM_W-1:0]   lim_line;
  logic               unused_cfg;

  assign x_restart  = frame_start | line_start;
  assign fire       = pix_en & ~x_restart;
  assign lim_en     = cfg_line_limit[LIM_EN_BIT];
  assign lim_line   = cfg_line_limit[LIM_LSB +: LIM_W];
  assign unused_cfg = ^{cfg_line_limit, x_pos, y_pos};

  fp_scaler_stepsel #(.STEP_W(STEP_W), .FRAC_W(FRAC_W)) u_stepsel (
    .base_step (cfg_xstep),
    .ovr       (cfg_xovr),
    .eff_step  (x_step)
  );

  fp_scaler_axis #(.POS_W(COORD_W), .STEP_W(STEP_W), .ACC_W(ACC_W)) u_xaxis (
    .clk     (clk),
    .rst     (rst),
    .restart (x_restart),
    .advance (pix_en),
    .step    (x_step),
    .win_lo  (cfg_hwin_start),
    .win_hi  (cfg_hwin_end),
    .pos     (x_pos),
    .acc     (x_acc),
    .in_win  (x_in_win)
  );

  fp_scaler_axis #(.POS_W(COORD_W), .STEP_W(STEP_W), .ACC_W(ACC_W)) u_yaxis (
    .clk     (clk),
    .rst     (rst),
    .restart (frame_start),
    .advance (line_start),
    .step    (cfg_ystep),
    .win_lo  (cfg_vwin_start),
    .win_hi  (cfg_vwin_end),
    .pos     (y_pos),
    .acc     (y_acc),
    .in_win  (y_in_win)
  );

  fp_scaler_out #(.IDX_W(IDX_W), .FRAC_W(FRAC_W), .LIM_W(LIM_W), .ACC_W(ACC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .x_in_win (x_in_win),
    .y_in_win (y_in_win),
    .x_acc    (x_acc),
    .y_acc    (y_acc),
    .lim_en   (lim_en),
    .lim_line (lim_line),
    .strobe_q (out_strobe),
    .valid_q  (out_valid),
    .sx_q     (out_src_x),
    .sy_q     (out_src_y)
  );
endmodule

// File: rtl/fp_scaler_chk.sv
module fp_scaler_chk #(
  parameter int IDX_W      = 16,
  parameter int CFG_W      = 32,
  parameter int LIM_W      = 12,
  parameter int LIM_LSB    = 16,
  parameter int LIM_EN_BIT = 28
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             line_start,
  input logic             pix_en,
  input logic [CFG_W-1:0] cfg_line_limit,
  input logic             out_strobe,
  input logic             out_valid,
  input logic [IDX_W-1:0] out_src_x,
  input logic [IDX_W-1:0] out_src_y
);
  // R2: a lone pixel strobe is echoed one clock later
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !line_start && !frame_start) |=> out_strobe);

  // R2: a strobe colliding with a line or frame start is dropped
  a_r2_collision_drop: assert property (@(posedge clk) disable iff (rst)
    (line_start || frame_start) |=> !out_strobe);

  // R9: no visible flag without a strobe
  a_r9_valid_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_strobe);

  // R3: blank pixels carry zero coordinates
  a_r3_blank_zero: assert property (@(posedge clk) disable iff (rst)
    (out_strobe && !out_valid) |-> (out_src_x == '0 && out_src_y == '0));

  // R7: clamp bound holds whenever the limit was enabled
  a_r7_clamp_bound: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(cfg_line_limit[LIM_EN_BIT]))
      |-> (out_src_y <= IDX_W'($past(cfg_line_limit[LIM_LSB +: LIM_W]))));
endmodule

bind fp_scaler fp_scaler_chk #(
  .IDX_W      (STEP_W + COORD_W - FRAC_W),
  .CFG_W      (CFG_W),
  .LIM_W      (LIM_W),
  .LIM_LSB    (LIM_LSB),
  .LIM_EN_BIT (LIM_EN_BIT)
) u_chk (.*);

// File: tb/fp_scaler_bench.sv
module fp_scaler_bench;
  localparam int COORD_W = 12;
  localparam int FRAC_W  = 12;
  localparam int STEP_W  = 16;
  localparam int IDX_W   = STEP_W + COORD_W - FRAC_W;

  logic               clk = 1'b0;
  logic               rst;
  logic               frame_start, line_start, pix_en;
  logic [STEP_W-1:0]  cfg_xstep, cfg_ystep;
  logic [FRAC_W:0]    cfg_xovr;
  logic [31:0]        cfg_line_limit;
  logic [COORD_W-1:0] cfg_hwin_start, cfg_hwin_end, cfg_vwin_start, cfg_vwin_end;
  logic               out_strobe, out_valid;
  logic [IDX_W-1:0]   out_src_x, out_src_y;

  always #5 clk = ~clk;

  fp_scaler u_fp_scaler (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .pix_en(pix_en), .cfg_xstep(cfg_xstep), .cfg_ystep(cfg_ystep),
    .cfg_xovr(cfg_xovr), .cfg_line_limit(cfg_line_limit),
    .cfg_hwin_start(cfg_hwin_start), .cfg_hwin_end(cfg_hwin_end),
    .cfg_vwin_start(cfg_vwin_start), .cfg_vwin_end(cfg_vwin_end),
    .out_strobe(out_strobe), .out_valid(out_valid),
    .out_src_x(out_src_x), .out_src_y(out_src_y)
  );

  int  n_chk = 0, n_fail = 0;
  bit  checking = 0, done = 0;
  int  mpx, mpy, xs, ys, e_sx, e_sy, limv;
  bit  e_strobe, e_valid, fire, clamp_hit;

  // Behavioural reference: per-cycle expectation from the requirements
  always @(posedge clk) begin
    if (rst) begin
      mpx = 0; mpy = 0; e_strobe = 0; e_valid = 0; e_sx = 0; e_sy = 0; clamp_hit = 0;
    end else begin
      xs   = cfg_xovr[12] ? int'(cfg_xovr[11:0]) * 2 : int'(cfg_xstep);   // R6
      ys   = int'(cfg_ystep);
      limv = int'(cfg_line_limit[27:16]);
      fire = pix_en && !line_start && !frame_start;                      // R2
      e_strobe = fire;
      if (fire) begin
        e_valid = mpx >= int'(cfg_hwin_start) && mpx <= int'(cfg_hwin_end) &&
                  mpy >= int'(cfg_vwin_start) && mpy <= int'(cfg_vwin_end);   // R3
        clamp_hit = 0;
        if (e_valid) begin
          e_sx = ((mpx - int'(cfg_hwin_start)) * xs) / 4096;               // R4
          e_sy = ((mpy - int'(cfg_vwin_start)) * ys) / 4096;               // R5
          if (cfg_line_limit[28] && e_sy > limv) begin e_sy = limv; clamp_hit = 1; end  // R7
        end else begin
          e_sx = 0; e_sy = 0;
        end
      end else begin
        e_valid = 0;                                                      // R9
      end
      if (frame_start)     begin mpx = 0; mpy = 0; end                    // R8
      else if (line_start) begin mpx = 0; mpy = mpy + 1; end
      else if (pix_en)     mpx = mpx + 1;
    end
  end

  task automatic report_fail(input string req, input int act, input int exp);
    n_fail++;
    $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
  endtask

  always @(negedge clk) begin
    if (checking && !rst && !done) begin
      n_chk++;
      if (out_strobe !== e_strobe)        report_fail("R2 strobe", int'(out_strobe), int'(e_strobe));
      else if (out_valid !== e_valid)     report_fail("R3 valid", int'(out_valid), int'(e_valid));
      else if (e_strobe && int'(out_src_x) != e_sx)
        report_fail(cfg_xovr[12] ? "R6 src_x" : "R4 src_x", int'(out_src_x), e_sx);
      else if (e_strobe && int'(out_src_y) != e_sy)
        report_fail(clamp_hit ? "R7 src_y" : "R5 src_y", int'(out_src_y), e_sy);
    end
  end

  task automatic drive(input bit fs, input bit ls, input bit pe);
    frame_start = fs; line_start = ls; pix_en = pe;
    @(negedge clk);
  endtask

  // R9: gap_every inserts idle cycles inside each line
  task automatic run_frame(input int lines, input int pix, input int gap_every);
    drive(1, 0, 0);
    for (int l = 0; l < lines; l++) begin
      if (l > 0) drive(0, 1, 0);
      for (int p = 0; p < pix; p++) begin
        drive(0, 0, 1);
        if (gap_every > 0 && (p % gap_every) == gap_every - 1) drive(0, 0, 0);
      end
      drive(0, 0, 0);
      drive(0, 0, 0);
    end
  endtask

  task automatic set_cfg(input int xst, input int yst, input int ovr, input int lim,
                         input int hs, input int he, input int vs, input int ve);
    cfg_xstep = STEP_W'(xst); cfg_ystep = STEP_W'(yst); cfg_xovr = 13'(ovr);
    cfg_line_limit = 32'(lim);
    cfg_hwin_start = COORD_W'(hs); cfg_hwin_end = COORD_W'(he);
    cfg_vwin_start = COORD_W'(vs); cfg_vwin_end = COORD_W'(ve);
  endtask

  task automatic finish_run;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; frame_start = 0; line_start = 0; pix_en = 0;
    set_cfg(4096, 4096, 0, 0, 0, 31, 0, 11);
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    n_chk++;
    if (out_strobe !== 1'b0 || out_valid !== 1'b0 || out_src_x !== '0 || out_src_y !== '0)
      report_fail("R1 reset outputs", int'(out_src_x) + int'(out_src_y) + int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_strobe !== 1'b0 || out_valid !== 1'b0)
      report_fail("R1 after reset", int'(out_strobe), 0);
    checking = 1;

    // R4 R5: identity mapping, full window
    run_frame(12, 32, 0);
    // R3 R4 R5 R9: 2x enlarge, centred window 4..27, lines 1..10, idle gaps
    set_cfg(2048, 2048, 0, 0, 4, 27, 1, 10);
    run_frame(12, 32, 5);
    // R6 R7: override replaces xstep (9999 ignored), clamp to line 5
    set_cfg(9999, 2730, 'h1555, (1 << 28) | (5 << 16), 2, 29, 0, 11);
    run_frame(12, 32, 3);
    // R7: limit field set but disabled, downscale on both axes
    set_cfg(6144, 8192, 'h0555, (2 << 16), 0, 31, 0, 11);
    run_frame(12, 32, 0);
    // R3: one-column, one-line window edge
    set_cfg(4096, 4096, 0, 0, 7, 7, 3, 3);
    run_frame(6, 16, 0);
    // R2 R8: collisions and mid-frame restart
    set_cfg(3000, 5000, 0, 0, 1, 20, 1, 9);
    drive(1, 0, 0);
    for (int p = 0; p < 6; p++) drive(0, 0, 1);
    drive(0, 1, 1);                       // R2: dropped pixel, new line
    for (int p = 0; p < 6; p++) drive(0, 0, 1);
    drive(1, 1, 0);                       // R8: frame wins, line count 0
    for (int p = 0; p < 6; p++) drive(0, 0, 1);
    drive(0, 1, 0);
    for (int p = 0; p < 8; p++) drive(0, 0, 1);
    drive(1, 0, 1);                       // R2 R8: pixel dropped on frame start
    for (int p = 0; p < 4; p++) drive(0, 0, 1);
    drive(0, 0, 0);
    drive(0, 0, 0);
    finish_run();
  end
endmodule